// File: doc/BRIEF.md
# Serial-Controlled Wiper Register Slave

This block is the digital side of a serially programmed potentiometer. A host drives a four-wire serial bus in clock-phase-zero mode: a select line (active low), a bit clock, a data input and a data output. The block keeps two small volatile registers. One is an 8-bit tap code that positions the wiper. The other is a control byte that holds a shutdown enable and a drive-mode choice for the serial output. Every command is a 16-bit word. The upper byte carries a 3-bit opcode and a 5-bit register address, and the lower byte carries the data.

Writes are held back until the host releases the select line. The word that is committed is the last whole 16 bits that arrived, so one long frame carrying many words can program several devices wired in series. Each device's output repeats its input 16 bit clocks later. A read word is answered with a header byte (111 followed by the address that was read) and then the register contents. The answer takes the place of the held word, so it comes out during the next 16 clocks of the same frame, or at the start of the next frame.

The bus pins are sampled by a faster system clock through a two-stage synchronizer. All edge handling happens in that clock domain.

Top module: `potspi_wiper_slave`

## Requirements
- R1: After reset the tap code is 80h and the control byte is 40h, so shutdown reads 0 and the open-drain select reads 0.
- R2: Input bits are taken on the rising bit-clock edge while select is low, most significant bit first. The output bit changes only after a falling bit-clock edge or after select falls.
- R3: Opcode 110 with address 00000 or 00001 loads the data byte into the tap code. The tap code changes only after select rises; it does not change while bits are still arriving.
- R4: Opcode 011 (any address), or opcode 110 with address 10000, writes the control byte. Only bit 6 and bit 1 are stored. Every other control bit reads back as 0.
- R5: The shutdown output is the inverse of control bit 6. Entering or leaving shutdown never changes the tap code.
- R6: Opcode 001 reads the control byte and replies with header F0h. Opcode 100 replies with header {111, address} followed by the tap code (address 00000 or 00001), the control byte (address 10000), or 00h for any other address. The reply appears on the output during the 16 clocks that follow the read word.
- R7: Opcodes 000, 010, 101 and 111, and opcode 110 to any unmapped address, change no register.
- R8: A frame that ends after fewer than 16 bits, or after a bit count that is not a multiple of 16, commits nothing.
- R9: Within a frame, the output repeats the input delayed by exactly 16 bit clocks, unless a read reply has been inserted. When one frame holds several words, only the last one is executed.
- R10: The output enable is low whenever select is high. When control bit 1 is 1 the output is open-drain: it drives only zeros and never drives a one.
- R11: After reset, no command is executed until select has been seen high and has then gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial bit clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out value |
| spi_sdo_oe | output | 1 | Drive enable for spi_sdo; 0 means high impedance |
| tap_code | output | 8 | Current wiper tap position |
| shutdown | output | 1 | 1 when the potentiometer is in shutdown |
| sdo_open_drain | output | 1 | 1 when the output is in open-drain mode |

## Verification
The checks assume that the host holds each bit-clock phase and each select level for several system clocks. They also assume that select is high for at least four system clocks between frames, so that the synchronized edges never merge. The stimulus uses four system clocks per bit-clock half period and a lead time of four clocks after select falls. It changes inputs only on falling system-clock edges and waits ten clocks after select rises. A behavioural reference model sees the pins through the same two-cycle delay and is compared with every output on every clock. Transaction-level checks decode the serial replies the way a host would, reading an undriven line as a pulled-up one.

// File: rtl/potspi_pkg.sv
`timescale 1ns/1ps
package potspi_pkg;
    localparam int FRAME_W = 16;
    localparam int BYTE_W  = 8;
    localparam int OP_W    = 3;
    localparam int ADDR_W  = 5;

    localparam logic [OP_W-1:0] OP_NOP    = 3'b000;
    localparam logic [OP_W-1:0] OP_CTL_RD = 3'b001;
    localparam logic [OP_W-1:0] OP_CTL_WR = 3'b011;
    localparam logic [OP_W-1:0] OP_SEL_RD = 3'b100;
    localparam logic [OP_W-1:0] OP_SEL_WR = 3'b110;
    localparam logic [OP_W-1:0] REPLY_TAG = 3'b111;

    localparam logic [ADDR_W-1:0] ADDR_TAP0 = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_TAP1 = 5'h01;
    localparam logic [ADDR_W-1:0] ADDR_CTL  = 5'h10;

    localparam logic [BYTE_W-1:0] TAP_RST  = 8'h80;
    localparam logic [BYTE_W-1:0] CTL_RST  = 8'h40;
    localparam int CTL_RUN_BIT   = 6;
    localparam int CTL_ODRAIN_BIT = 1;
    localparam logic [BYTE_W-1:0] CTL_KEEP = 8'h42;

    typedef struct packed {
        logic [BYTE_W-1:0] tap;
        logic [BYTE_W-1:0] ctl;
    } potregs_t;
endpackage

// File: rtl/potspi_pin_sync.sv
`timescale 1ns/1ps
module potspi_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] level_o
);
    logic [STAGES-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pins_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/potspi_edge.sv
`timescale 1ns/1ps
module potspi_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_edge
            assign rise_o[g] = level_i[g] & ~prev_q[g];
            assign fall_o[g] = ~level_i[g] & prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/potspi_frame.sv
`timescale 1ns/1ps
module potspi_frame
    import potspi_pkg::*;
#(
    parameter int WORD_W = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sdi_i,
    output logic [WORD_W-1:0] probe_word_o,
    input  logic              probe_is_read_i,
    input  logic [WORD_W-1:0] probe_reply_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] commit_word_o,
    output logic              sdo_bit_o,
    output logic              active_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              active;
        logic              sdo;
    } frame_t;

    frame_t st_d, st_q;
    logic [WORD_W-1:0] shifted;
    logic              wrap;

    always_comb begin
        shifted      = {st_q.shift[WORD_W-2:0], sdi_i};
        wrap         = (st_q.cnt == CNT_LAST);
        probe_word_o = sel_fall_i ? st_q.shift : shifted;
    end

    always_comb begin
        st_d = st_q;
        if (sel_fall_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.full   = 1'b0;
            if (probe_is_read_i) begin
                st_d.shift = probe_reply_i;
                st_d.sdo   = probe_reply_i[WORD_W-1];
            end else begin
                st_d.sdo   = st_q.shift[WORD_W-1];
            end
        end else if (sel_rise_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (sck_rise_i) begin
                if (wrap) begin
                    st_d.cnt  = '0;
                    st_d.full = 1'b1;
                    st_d.shift = probe_is_read_i ? probe_reply_i : shifted;
                end else begin
                    st_d.cnt   = st_q.cnt + 1'b1;
                    st_d.shift = shifted;
                end
            end
            if (sck_fall_i) begin
                st_d.sdo = st_q.shift[WORD_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o      = sel_rise_i & st_q.active & st_q.full & (st_q.cnt == '0);
    assign commit_word_o = st_q.shift;
    assign sdo_bit_o     = st_q.sdo;
    assign active_o      = st_q.active;
endmodule

// File: rtl/potspi_regs.sv
`timescale 1ns/1ps
module potspi_regs
    import potspi_pkg::*;
#(
    parameter int WORD_W = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] commit_word_i,
    input  logic [WORD_W-1:0] probe_word_i,
    output logic              probe_is_read_o,
    output logic [WORD_W-1:0] probe_reply_o,
    output logic [BYTE_W-1:0] tap_o,
    output logic              shutdown_o,
    output logic              odrain_o
);
    localparam int OP_LSB   = WORD_W - OP_W;
    localparam int ADDR_LSB = OP_LSB - ADDR_W;

    potregs_t rg_d, rg_q;

    logic [OP_W-1:0]   p_op, c_op;
    logic [ADDR_W-1:0] p_addr, c_addr, hdr_addr;
    logic [BYTE_W-1:0] c_data, rd_data;

    function automatic logic is_tap(input logic [ADDR_W-1:0] a);
        return (a == ADDR_TAP0) || (a == ADDR_TAP1);
    endfunction

    always_comb begin
        p_op     = probe_word_i[WORD_W-1 -: OP_W];
        p_addr   = probe_word_i[OP_LSB-1 -: ADDR_W];
        probe_is_read_o = 1'b0;
        hdr_addr = p_addr;
        rd_data  = '0;
        if (p_op == OP_CTL_RD) begin
            probe_is_read_o = 1'b1;
            hdr_addr = ADDR_CTL;
            rd_data  = rg_q.ctl;
        end else if (p_op == OP_SEL_RD) begin
            probe_is_read_o = 1'b1;
            if (is_tap(p_addr)) begin
                rd_data = rg_q.tap;
            end else if (p_addr == ADDR_CTL) begin
                rd_data = rg_q.ctl;
            end
        end
        probe_reply_o = {REPLY_TAG, hdr_addr, rd_data};
    end

    always_comb begin
        c_op   = commit_word_i[WORD_W-1 -: OP_W];
        c_addr = commit_word_i[OP_LSB-1 -: ADDR_W];
        c_data = commit_word_i[ADDR_LSB-1:0];
        rg_d   = rg_q;
        if (commit_i) begin
            if (c_op == OP_CTL_WR) begin
                rg_d.ctl = c_data & CTL_KEEP;
            end else if (c_op == OP_SEL_WR) begin
                if (is_tap(c_addr)) begin
                    rg_d.tap = c_data;
                end else if (c_addr == ADDR_CTL) begin
                    rg_d.ctl = c_data & CTL_KEEP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.tap <= TAP_RST;
            rg_q.ctl <= CTL_RST;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign tap_o      = rg_q.tap;
    assign shutdown_o = ~rg_q.ctl[CTL_RUN_BIT];
    assign odrain_o   = rg_q.ctl[CTL_ODRAIN_BIT];
endmodule

// File: rtl/potspi_wiper_slave.sv
`timescale 1ns/1ps
module potspi_wiper_slave
    import potspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [BYTE_W-1:0] tap_code,
    output logic              shutdown,
    output logic              sdo_open_drain
);
    localparam int PIN_N  = 3;
    localparam int PIN_CS = 2;
    localparam int PIN_CK = 1;
    localparam int PIN_DI = 0;

    logic [PIN_N-1:0] pin_lvl;
    logic [1:0]       edge_rise, edge_fall;
    logic [FRAME_W-1:0] probe_word, probe_reply, commit_word;
    logic probe_is_read, commit, sdo_bit, active;

    potspi_pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  ({spi_cs_n, spi_sck, spi_sdi}),
        .level_o (pin_lvl)
    );

    potspi_edge #(.N(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({pin_lvl[PIN_CS], pin_lvl[PIN_CK]}),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    potspi_frame #(.WORD_W(FRAME_W)) u_frame (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_fall_i      (edge_fall[1]),
        .sel_rise_i      (edge_rise[1]),
        .sck_rise_i      (edge_rise[0]),
        .sck_fall_i      (edge_fall[0]),
        .sdi_i           (pin_lvl[PIN_DI]),
        .probe_word_o    (probe_word),
        .probe_is_read_i (probe_is_read),
        .probe_reply_i   (probe_reply),
        .commit_o        (commit),
        .commit_word_o   (commit_word),
        .sdo_bit_o       (sdo_bit),
        .active_o        (active)
    );

    potspi_regs #(.WORD_W(FRAME_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .commit_i        (commit),
        .commit_word_i   (commit_word),
        .probe_word_i    (probe_word),
        .probe_is_read_o (probe_is_read),
        .probe_reply_o   (probe_reply),
        .tap_o           (tap_code),
        .shutdown_o      (shutdown),
        .odrain_o        (sdo_open_drain)
    );

    assign spi_sdo    = sdo_bit & ~sdo_open_drain;
    assign spi_sdo_oe = ~spi_cs_n & active & (~sdo_open_drain | ~sdo_bit);
endmodule

// File: rtl/potspi_wiper_slave_chk.sv
`timescale 1ns/1ps
module potspi_wiper_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sdo,
    input logic       spi_sdo_oe,
    input logic [7:0] tap_code,
    input logic       shutdown,
    input logic       sdo_open_drain
);
    AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> (tap_code == 8'h80 && !shutdown && !sdo_open_drain)); // R1
    AST_TAP_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tap_code) |-> $past(spi_cs_n, 2)); // R3
    AST_SHDN_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(shutdown) |-> $stable(tap_code)); // R5
    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sdo_oe); // R10
    AST_ODRAIN_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (spi_sdo_oe && sdo_open_drain) |-> !spi_sdo); // R10
endmodule

bind potspi_wiper_slave potspi_wiper_slave_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_cs_n       (spi_cs_n),
    .spi_sdo        (spi_sdo),
    .spi_sdo_oe     (spi_sdo_oe),
    .tap_code       (tap_code),
    .shutdown       (shutdown),
    .sdo_open_drain (sdo_open_drain)
);

// File: tb/potspi_wiper_slave_tb.sv
`timescale 1ns/1ps
module potspi_wiper_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b0;
    logic spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe, shutdown, sdo_open_drain;
    logic [7:0] tap_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    potspi_wiper_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .tap_code(tap_code), .shutdown(shutdown), .sdo_open_drain(sdo_open_drain)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0]  h_cs, h_sck, h_sdi;
    logic [15:0] m_held;
    int          m_cnt;
    bit          m_full, m_active, m_sdo;
    logic [7:0]  m_tap, m_ctl;
    logic [16:0] m_r;

    function automatic logic [16:0] m_reply(input logic [15:0] w, input logic [7:0] tp, input logic [7:0] ct);
        logic [2:0] op;
        logic [4:0] a;
        logic [7:0] d;
        op = w[15:13];
        a  = w[12:8];
        if (op == 3'b001) return {1'b1, 8'hF0, ct};
        if (op == 3'b100) begin
            if (a == 5'd0 || a == 5'd1) d = tp;
            else if (a == 5'd16)       d = ct;
            else                       d = 8'h00;
            return {1'b1, 3'b111, a, d};
        end
        return 17'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h_cs = '0; h_sck = '0; h_sdi = '0;
            m_held = '0; m_cnt = 0; m_full = 0; m_active = 0; m_sdo = 0;
            m_tap = 8'h80; m_ctl = 8'h40;
        end else begin
            h_cs  = {h_cs[2:0], spi_cs_n};
            h_sck = {h_sck[2:0], spi_sck};
            h_sdi = {h_sdi[2:0], spi_sdi};
            if (h_cs[3] && !h_cs[2]) begin
                m_active = 1; m_cnt = 0; m_full = 0;
                m_r = m_reply(m_held, m_tap, m_ctl);
                if (m_r[16]) m_held = m_r[15:0];
                m_sdo = m_held[15];
            end else if (!h_cs[3] && h_cs[2]) begin
                if (m_active && m_full && m_cnt == 0) begin
                    if (m_held[15:13] == 3'b011) m_ctl = m_held[7:0] & 8'h42;
                    else if (m_held[15:13] == 3'b110) begin
                        if (m_held[12:8] <= 5'd1) m_tap = m_held[7:0];
                        else if (m_held[12:8] == 5'd16) m_ctl = m_held[7:0] & 8'h42;
                    end
                end
                m_active = 0;
            end else if (m_active) begin
                if (!h_sck[3] && h_sck[2]) begin
                    m_held = {m_held[14:0], h_sdi[2]};
                    m_cnt++;
                    if (m_cnt == 16) begin
                        m_cnt = 0; m_full = 1;
                        m_r = m_reply(m_held, m_tap, m_ctl);
                        if (m_r[16]) m_held = m_r[15:0];
                    end
                end
                if (h_sck[3] && !h_sck[2]) m_sdo = m_held[15];
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic exp_oe;
            check("R3 tap per clock", tap_code, m_tap);
            check("R5 shutdown per clock", shutdown, !m_ctl[6]);
            check("R10 drive mode per clock", sdo_open_drain, m_ctl[1]);
            exp_oe = !spi_cs_n && m_active && (!m_ctl[1] || !m_sdo);
            check("R10 enable per clock", spi_sdo_oe, exp_oe);
            if (exp_oe) check("R9 serial out per clock", spi_sdo, m_sdo & !m_ctl[1]);
        end
    end

    // ---------------- host side ----------------
    task automatic frame(input int nbits, input logic [63:0] tx, input bit release_sel, output logic [63:0] rx);
        rx = '0;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_sdi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = spi_sdo_oe ? spi_sdo : 1'b1;
            spi_sck = 1'b1;
            repeat (4) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        if (release_sel) begin
            spi_cs_n = 1'b1;
            repeat (10) @(negedge clk);
        end
    endtask

    task automatic release_select();
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr16(input logic [15:0] w);
        logic [63:0] rx;
        frame(16, {48'd0, w}, 1'b1, rx);
    endtask

    task automatic rd16(input logic [15:0] w, output logic [15:0] reply);
        logic [63:0] rx;
        frame(32, {32'd0, w, 16'h0000}, 1'b1, rx);
        reply = rx[15:0];
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rx;
        logic [15:0] rep;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tap reset", tap_code, 8'h80);
        check("R1 shutdown reset", shutdown, 1'b0);
        check("R1 drive mode reset", sdo_open_drain, 1'b0);
        check("R10 no drive before frame", spi_sdo_oe, 1'b0);

        // select low since reset: no falling edge seen yet
        wr16(16'hC011);
        check("R11 no command before first select fall", tap_code, 8'h80);

        frame(16, {48'd0, 16'hC0A5}, 1'b0, rx);
        check("R3 tap held until select rises", tap_code, 8'h80);
        release_select();
        check("R3 tap written", tap_code, 8'hA5);
        wr16(16'hC100);
        check("R3 tap zero via address 1", tap_code, 8'h00);
        wr16(16'hC0FF);
        check("R3 tap full scale", tap_code, 8'hFF);

        wr16(16'hC033);
        frame(16, 64'd0, 1'b1, rx);
        check("R9 pass-through delay 16", rx[15:0], 16'hC033);
        check("R3 tap after pass-through", tap_code, 8'h33);

        frame(32, {32'd0, 16'hC011, 16'hC022}, 1'b1, rx);
        check("R9 last word wins", tap_code, 8'h22);

        frame(12, {52'd0, 12'hC05}, 1'b1, rx);
        check("R8 short frame ignored", tap_code, 8'h22);
        frame(20, {44'd0, 16'hC044, 4'h5}, 1'b1, rx);
        check("R8 ragged frame ignored", tap_code, 8'h22);

        rd16(16'h8000, rep);
        check("R6 read tap address 0", rep, 16'hE022);
        rd16(16'h8100, rep);
        check("R6 read tap address 1", rep, 16'hE122);
        rd16(16'h2000, rep);
        check("R6 read control", rep, 16'hF040);
        rd16(16'h8700, rep);
        check("R6 read unmapped", rep, 16'hE700);

        wr16(16'h60FF);
        check("R4 control write keeps bit 1", sdo_open_drain, 1'b1);
        check("R4 control write keeps bit 6", shutdown, 1'b0);
        rd16(16'h2000, rep);
        check("R4 unused control bits zero", rep, 16'hF042);
        check("R10 open-drain deselected", spi_sdo_oe, 1'b0);
        rd16(16'h8000, rep);
        check("R10 open-drain read with pull-up", rep, 16'hE022);
        wr16(16'hD040);
        check("R4 control write via address 10000", sdo_open_drain, 1'b0);

        wr16(16'hD000);
        check("R5 shutdown entered", shutdown, 1'b1);
        check("R5 tap kept in shutdown", tap_code, 8'h22);
        rd16(16'h8000, rep);
        check("R5 tap readback in shutdown", rep, 16'hE022);
        wr16(16'hD040);
        check("R5 shutdown left", shutdown, 1'b0);
        check("R5 tap kept after shutdown", tap_code, 8'h22);

        wr16(16'h4055);
        check("R7 opcode 010 ignored", tap_code, 8'h22);
        wr16(16'hA055);
        check("R7 opcode 101 ignored", tap_code, 8'h22);
        wr16(16'hE000);
        check("R7 opcode 111 ignored", shutdown, 1'b0);
        wr16(16'hC555);
        check("R7 unmapped write ignored", tap_code, 8'h22);
        wr16(16'h0055);
        check("R7 no-op ignored", tap_code, 8'h22);
        rd16(16'h2000, rep);
        check("R7 control untouched", rep, 16'hF040);

        wr16(16'hC096);
        rd16(16'h8000, rep);
        check("R2 bit order round trip", rep, 16'hE096);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule